// File: doc/BRIEF.md
# Branch Direction Predictor with Group-Shared Confidence

This block predicts whether a conditional branch will be taken, using a table looked up by the low bits of the branch address. Every table entry holds its own direction bit. The strong/weak confidence bit is different: one bit serves a group of neighbouring entries. Most trained entries sit in the strong state, so sharing confidence costs little accuracy. At a fixed number of storage bits, the table can then hold direction state for more branches than a table of private 2-bit counters.

The fetch side presents an address on the predict port and reads a taken/not-taken answer in the same cycle. The answer is combinational from the table state. When a branch resolves, the execute side presents its address and actual outcome on the update port for one cycle. The table changes on the next clock edge.

The direction index is the low `DIR_IDX_W` address bits. The confidence index is the upper `DIR_IDX_W - GROUP_LOG2` bits of that direction index. As a result, `2^GROUP_LOG2` consecutive entries share one confidence bit. The parameters must satisfy `GROUP_LOG2 < DIR_IDX_W`.

Top module: `branch_dir_predictor`

## Requirements
- R1: After reset, every direction bit is not-taken (prediction 0) and every confidence bit is weak.
- R2: The prediction for an address is the direction bit of entry `addr[DIR_IDX_W-1:0]`; address bits above that slice have no effect.
- R3: An update whose outcome equals the entry's current direction bit sets the group's shared confidence bit to strong.
- R4: An update whose outcome differs from the entry's direction bit while the group is strong sets the group to weak and leaves the direction bit unchanged.
- R5: An update whose outcome differs from the entry's direction bit while the group is weak replaces the direction bit with the outcome and keeps the group weak.
- R6: Entries whose indices differ only in the low `GROUP_LOG2` bits share one confidence bit, so training one entry changes how a mispredict on its neighbour is handled.
- R7: An update changes only the direction bit of its own entry; the predictions of all other entries stay the same.
- R8: When predict and update name the same entry in one cycle, the prediction shows the value before the update, and the new value appears from the next cycle on.
- R9: With `upd_valid` low, the other update inputs have no effect on any direction or confidence bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_addr | input | ADDR_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench builds the predictor with ADDR_W = 32, DIR_IDX_W = 6 and GROUP_LOG2 = 2. That gives 64 direction entries in 16 groups of four. With these values, a full sweep of every entry after reset takes little time. Groups of four leave room to train one member and then mispredict another (entries 8 and 9). The wide address lets the bench set high bits that must alias onto the same entry. Confidence is never visible at the ports, so the bench reads it back through the outcome of a later mispredict: a direction that holds means the group was strong, and a direction that flips means it was weak.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // One write command for both tables, produced by the update decision logic.
    typedef struct packed {
        logic dir_we;
        logic dir_val;
        logic conf_we;
        logic conf_val;
    } bp_wr_t;

    localparam logic CONF_WEAK   = 1'b0;
    localparam logic CONF_STRONG = 1'b1;

endpackage

// File: rtl/bp_bit_table.sv
module bp_bit_table #(
    parameter int   IDX_W = 6,
    parameter logic INIT  = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  wr_val,
    output logic [(1<<IDX_W)-1:0] bits_q
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] bits_d;

    always_comb begin
        bits_d = bits_q;
        if (wr_en) begin
            bits_d[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= {ENTRIES{INIT}};
        end else begin
            bits_q <= bits_d;
        end
    end

endmodule

// File: rtl/bp_update_logic.sv
module bp_update_logic
    import bp_pkg::*;
(
    input  logic   upd_valid,
    input  logic   upd_taken,
    input  logic   cur_dir,
    input  logic   cur_conf,
    output bp_wr_t wr_cmd
);
    always_comb begin
        wr_cmd = '0;
        if (upd_valid) begin
            if (cur_dir == upd_taken) begin
                // correct: group becomes strong
                wr_cmd.conf_we  = 1'b1;
                wr_cmd.conf_val = CONF_STRONG;
            end else if (cur_conf == CONF_STRONG) begin
                // wrong while strong: weaken only
                wr_cmd.conf_we  = 1'b1;
                wr_cmd.conf_val = CONF_WEAK;
            end else begin
                // wrong while weak: adopt outcome
                wr_cmd.dir_we  = 1'b1;
                wr_cmd.dir_val = upd_taken;
            end
        end
    end

endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
    import bp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DIR_IDX_W  = 6,
    parameter int GROUP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              pred_taken,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken
);
    localparam int CONF_IDX_W  = DIR_IDX_W - GROUP_LOG2;
    localparam int DIR_ENTRIES = 1 << DIR_IDX_W;
    localparam int CONF_GROUPS = 1 << CONF_IDX_W;

    logic [DIR_IDX_W-1:0]   pred_didx;
    logic [DIR_IDX_W-1:0]   upd_didx;
    logic [CONF_IDX_W-1:0]  upd_cidx;
    logic [DIR_ENTRIES-1:0] dir_bits;
    logic [CONF_GROUPS-1:0] conf_bits;
    logic                   upd_dir;
    logic                   upd_conf;
    bp_wr_t                 wr_cmd;
    logic                   unused_hi_bits;

    assign pred_didx = pred_addr[DIR_IDX_W-1:0];
    assign upd_didx  = upd_addr[DIR_IDX_W-1:0];
    assign upd_cidx  = upd_didx[DIR_IDX_W-1:GROUP_LOG2];
    assign unused_hi_bits = ^{pred_addr[ADDR_W-1:DIR_IDX_W], upd_addr[ADDR_W-1:DIR_IDX_W]};

    // Reads come from registered state: a same-cycle update is not forwarded.
    assign pred_taken = dir_bits[pred_didx];
    assign upd_dir    = dir_bits[upd_didx];
    assign upd_conf   = conf_bits[upd_cidx];

    bp_update_logic u_decide (
        .upd_valid (upd_valid),
        .upd_taken (upd_taken),
        .cur_dir   (upd_dir),
        .cur_conf  (upd_conf),
        .wr_cmd    (wr_cmd)
    );

    bp_bit_table #(.IDX_W(DIR_IDX_W), .INIT(1'b0)) u_dir_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_cmd.dir_we),
        .wr_idx (upd_didx),
        .wr_val (wr_cmd.dir_val),
        .bits_q (dir_bits)
    );

    bp_bit_table #(.IDX_W(CONF_IDX_W), .INIT(CONF_WEAK)) u_conf_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_cmd.conf_we),
        .wr_idx (upd_cidx),
        .wr_val (wr_cmd.conf_val),
        .bits_q (conf_bits)
    );

    // R3
    conf_strong_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_dir == upd_taken)) |=> conf_bits[$past(upd_cidx)]);

    // R4
    weaken_on_strong_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_dir != upd_taken) && upd_conf)
        |=> (!conf_bits[$past(upd_cidx)] && (dir_bits[$past(upd_didx)] == $past(upd_dir))));

    // R5
    flip_on_weak_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_dir != upd_taken) && !upd_conf)
        |=> ((dir_bits[$past(upd_didx)] == $past(upd_taken)) && !conf_bits[$past(upd_cidx)]));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(dir_bits) && $stable(conf_bits)));

endmodule

// File: tb/branch_dir_predictor_tb.sv
module branch_dir_predictor_tb_top;

    localparam int ADDR_W     = 32;
    localparam int DIR_IDX_W  = 6;
    localparam int GROUP_LOG2 = 2;
    localparam int NDIR       = 1 << DIR_IDX_W;
    localparam int NCONF      = 1 << (DIR_IDX_W - GROUP_LOG2);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] pred_addr = '0;
    logic              pred_taken;
    logic              upd_valid = 1'b0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic              upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic ref_dir  [NDIR];
    logic ref_conf [NCONF];

    always #2 clk = ~clk;

    branch_dir_predictor #(
        .ADDR_W(ADDR_W), .DIR_IDX_W(DIR_IDX_W), .GROUP_LOG2(GROUP_LOG2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pred_addr(pred_addr), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    function automatic void model_update(input logic [ADDR_W-1:0] a, input logic t);
        int di = int'(a[DIR_IDX_W-1:0]);
        int ci = di >> GROUP_LOG2;
        if (ref_dir[di] == t) ref_conf[ci] = 1'b1;
        else if (ref_conf[ci]) ref_conf[ci] = 1'b0;
        else ref_dir[di] = t;
    endfunction

    task automatic do_update(input logic [ADDR_W-1:0] a, input logic t);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_addr  = a;
        upd_taken = t;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        model_update(a, t);
    endtask

    task automatic expect_pred(input string req, input logic [ADDR_W-1:0] a);
        pred_addr = a;
        #1;
        check(req, pred_taken, ref_dir[int'(a[DIR_IDX_W-1:0])]);
    endtask

    task automatic t_reset;
        for (int i = 0; i < NDIR; i++) begin
            pred_addr = ADDR_W'(i);
            #1;
            check("R1", pred_taken, 1'b0);
        end
    endtask

    task automatic t_single_entry;
        do_update(32'd5, 1'b1);
        check("R5", pred_taken === 1'b1 || pred_addr != 32'd5, 1'b1);
        expect_pred("R5", 32'd5);
        do_update(32'd5, 1'b1);
        expect_pred("R3", 32'd5);
        do_update(32'd5, 1'b0);
        pred_addr = 32'd5; #1;
        check("R4", pred_taken, 1'b1);
        do_update(32'd5, 1'b0);
        pred_addr = 32'd5; #1;
        check("R5", pred_taken, 1'b0);
    endtask

    task automatic t_shared_group;
        do_update(32'd8, 1'b1);
        do_update(32'd8, 1'b1);
        pred_addr = 32'd8; #1;
        check("R3", pred_taken, 1'b1);
        do_update(32'd9, 1'b1);
        pred_addr = 32'd9; #1;
        check("R6", pred_taken, 1'b0);
        do_update(32'd9, 1'b1);
        pred_addr = 32'd9; #1;
        check("R6", pred_taken, 1'b1);
        pred_addr = 32'd8; #1;
        check("R7", pred_taken, 1'b1);
    endtask

    task automatic t_isolation;
        for (int i = 0; i < NDIR; i++) begin
            expect_pred("R7", ADDR_W'(i));
        end
        pred_addr = 32'd10; #1;
        check("R7", pred_taken, 1'b0);
    endtask

    task automatic t_alias;
        do_update(32'hA000_0013, 1'b1);
        pred_addr = 32'd19; #1;
        check("R2", pred_taken, 1'b1);
        pred_addr = 32'h5550_0013; #1;
        check("R2", pred_taken, 1'b1);
        pred_addr = 32'hFFFF_FFD4; #1;
        check("R2", pred_taken, ref_dir[20]);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        pred_addr = 32'd33;
        upd_valid = 1'b1;
        upd_addr  = 32'd33;
        upd_taken = 1'b1;
        #1;
        check("R8", pred_taken, 1'b0);
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        model_update(32'd33, 1'b1);
        check("R8", pred_taken, 1'b1);
    endtask

    task automatic t_idle_update;
        do_update(32'd40, 1'b1);
        do_update(32'd40, 1'b1);
        @(negedge clk);
        upd_valid = 1'b0;
        upd_addr  = 32'd40;
        upd_taken = 1'b0;
        @(posedge clk);
        #1;
        pred_addr = 32'd40; #1;
        check("R9", pred_taken, 1'b1);
        do_update(32'd40, 1'b0);
        pred_addr = 32'd40; #1;
        check("R9", pred_taken, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < NDIR; i++) ref_dir[i] = 1'b0;
        for (int i = 0; i < NCONF; i++) ref_conf[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_single_entry();
        t_shared_group();
        t_isolation();
        t_alias();
        t_same_cycle();
        t_idle_update();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

endmodule